// File: doc/BRIEF.md
# Multi-Stream Sequential Line Prefetch Buffers

This block sits next to a data cache and keeps several short queues of cache lines that are fetched ahead of demand. Each queue follows one stream of consecutive line addresses. When the cache misses, it presents the missing line address, and the block compares that address with the oldest entry of every queue at the same time. If one of those entries matches, its data goes back to the cache and the entry leaves its queue.

If no oldest entry matches, the block answers "not held". It then takes the queue that was used least recently, clears it, and starts a new stream at the line that follows the miss. Each queue refills itself from memory whenever it has a free entry and the memory bus is not busy. A round-robin arbiter shares a single memory request port among the queues.

Every memory request carries a tag that names the queue, the queue's current generation and the entry slot. A response whose generation no longer matches its queue belongs to a cleared stream and is dropped.

Top module: `sbp_stream_prefetch`

## Requirements
- R1: While reset is held and after it is released, ret_valid and mem_req_valid stay low. No queue issues any memory request until the first miss has allocated a stream.
- R2: The block accepts miss_req only in a cycle where ret_valid is low. If the oldest entry of a queue matches miss_line and its data has arrived, ret_valid rises for exactly one cycle, one clock after the miss is accepted. In that cycle ret_hit is 1 and ret_data is the data memory returned for that line.
- R3: If no oldest entry matches, ret_valid pulses one clock after acceptance with ret_hit 0. One queue is then cleared, and its first memory request is for line miss_line + 1.
- R4: The queue cleared on a no-match miss is the least recently used one. A queue counts as used when it supplies a hit or is allocated to a new stream.
- R5: A memory request is issued only while mem_busy is low, and only for a queue that has an allocated stream and a free entry. A queue never holds more than DEPTH entries, so with mem_busy low the block issues exactly NBUF*DEPTH requests after NBUF streams have been allocated, and no more.
- R6: Successive memory requests of one stream are for successive line addresses, each one greater than the one before.
- R7: If the oldest entry matches but its data has not yet arrived, no response is given. ret_valid pulses with ret_hit 1 and the correct data only after the data arrives.
- R8: The request tag is laid out as {queue index in bits 6:5, generation in bits 4:2, slot in bits 1:0}, and memory echoes it on mem_rsp_tag. A response whose generation differs from the queue's current one is discarded and never reaches ret_data.
- R9: When several queues want to issue in the same cycle, grants rotate. The search starts at the queue after the last one granted, so while all queues keep wanting, the granted queue index steps by one (modulo NBUF) on each request.
- R10: A hit removes the matched entry, so the next line of that stream becomes the oldest entry and a miss on it also hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | Cache miss lookup, held until ret_valid is seen |
| miss_line | input | LW | Line address of the missing line |
| ret_valid | output | 1 | One-cycle answer to the accepted miss |
| ret_hit | output | 1 | 1 when the line is supplied from a queue |
| ret_data | output | DW | Line data for a hit |
| mem_req_valid | output | 1 | Memory fetch request this cycle |
| mem_req_line | output | LW | Line address to fetch |
| mem_req_tag | output | TW | Queue, generation and slot of the request |
| mem_busy | input | 1 | Memory bus busy; no request may issue |
| mem_rsp_valid | input | 1 | Memory response this cycle |
| mem_rsp_tag | input | TW | Echoed request tag |
| mem_rsp_data | input | DW | Returned line data |

## Verification
The assertions assume that memory answers every request exactly once with the tag it was given. They also assume the cache holds miss_req and miss_line steady until it sees ret_valid, then drops miss_req before the next edge. The bench's memory model keeps a queue of tagged requests and answers each one after a bounded latency, and it never invents a tag. The cache side of the bench raises a miss only from its miss task, which waits for the pulse and releases the request at the following falling edge.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  // Index reached by stepping off places forward from base on a ring of n.
  function automatic int unsigned ring_idx(int unsigned base, int unsigned off,
                                           int unsigned n);
    return (base + off) % n;
  endfunction

endpackage

// File: rtl/sbp_rr_arb.sv
module sbp_rr_arb #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          en,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  import sbp_pkg::*;

  logic [IW-1:0] ptr;
  int unsigned   cand;

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    cand    = 0;
    for (int k = 0; k < int'(N); k++) begin
      cand = ring_idx(int'(ptr), k, N);
      if (en && !gnt_any && req[cand]) begin
        gnt_any       = 1'b1;
        gnt[cand]     = 1'b1;
        gnt_idx       = cand[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (gnt_any) ptr <= (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
  end

  p_gnt_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_gnt_requested_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/sbp_lru.sv
module sbp_lru #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  // rank 0 = most recently used, rank N-1 = victim
  logic [IW-1:0] rank [N];
  logic [N-1:0]  is_lru;

  always_comb begin
    victim_idx = '0;
    is_lru     = '0;
    for (int j = 0; j < int'(N); j++) begin
      if (rank[j] == IW'(N-1)) begin
        is_lru[j]  = 1'b1;
        victim_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < int'(N); j++) rank[j] <= IW'(j);
    end else if (touch) begin
      for (int j = 0; j < int'(N); j++) begin
        if (IW'(j) == touch_idx)            rank[j] <= '0;
        else if (rank[j] < rank[touch_idx]) rank[j] <= rank[j] + 1'b1;
      end
    end
  end

  p_single_victim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_lru) == 1);

endmodule

// File: rtl/sbp_buf.sv
module sbp_buf #(
  parameter int unsigned LW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned GW    = 3,
  localparam int unsigned SW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [LW-1:0] flush_line,
  input  logic          pop,
  input  logic          grant,
  input  logic          rsp_wr,
  input  logic [SW-1:0] rsp_slot,
  input  logic [DW-1:0] rsp_data,
  output logic          want,
  output logic [LW-1:0] req_line,
  output logic [SW-1:0] req_slot,
  output logic [GW-1:0] gen,
  output logic          head_valid,
  output logic          head_arrived,
  output logic [LW-1:0] head_line,
  output logic [DW-1:0] head_data
);

  function automatic logic [LW-1:0] step_line(logic [LW-1:0] l);
    return l + 1'b1;
  endfunction

  function automatic logic [SW-1:0] step_ptr(logic [SW-1:0] p);
    return (p == SW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  logic             active;
  logic [LW-1:0]    nxt;
  logic [SW-1:0]    hd, tl;
  logic [CW-1:0]    cnt;
  logic [DEPTH-1:0] e_vld, e_arr;
  logic [LW-1:0]    e_line [DEPTH];
  logic [DW-1:0]    e_data [DEPTH];
  logic             rsp_take;

  assign want         = active && !flush && (cnt < CW'(DEPTH));
  assign req_line     = nxt;
  assign req_slot     = tl;
  assign head_valid   = e_vld[hd];
  assign head_arrived = e_arr[hd];
  assign head_line    = e_line[hd];
  assign head_data    = e_data[hd];
  assign rsp_take     = rsp_wr && e_vld[rsp_slot] && !e_arr[rsp_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      nxt    <= '0;
      hd     <= '0;
      tl     <= '0;
      cnt    <= '0;
      gen    <= '0;
      e_vld  <= '0;
      e_arr  <= '0;
    end else if (flush) begin
      active <= 1'b1;
      nxt    <= step_line(flush_line);
      hd     <= '0;
      tl     <= '0;
      cnt    <= '0;
      gen    <= gen + 1'b1;
      e_vld  <= '0;
      e_arr  <= '0;
    end else begin
      if (grant) begin
        e_line[tl] <= nxt;
        e_vld[tl]  <= 1'b1;
        e_arr[tl]  <= 1'b0;
        tl         <= step_ptr(tl);
        nxt        <= step_line(nxt);
      end
      if (rsp_take) begin
        e_arr[rsp_slot]  <= 1'b1;
        e_data[rsp_slot] <= rsp_data;
      end
      if (pop) begin
        e_vld[hd] <= 1'b0;
        e_arr[hd] <= 1'b0;
        hd        <= step_ptr(hd);
      end
      if (grant && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !grant) cnt <= cnt - 1'b1;
    end
  end

  // Independent record of the last line requested by this stream.
  logic [LW-1:0] chk_last;
  logic          chk_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_last <= '0;
      chk_ok   <= 1'b0;
    end else if (flush) begin
      chk_last <= flush_line;
      chk_ok   <= 1'b1;
    end else if (grant) begin
      chk_last <= req_line;
    end
  end

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_grant_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (active && cnt < CW'(DEPTH)));
  p_stride_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (grant && chk_ok) |-> (req_line == LW'(chk_last + 1'b1)));
  p_pop_arrived_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (head_valid && head_arrived));

endmodule

// File: rtl/sbp_stream_prefetch.sv
module sbp_stream_prefetch #(
  parameter int unsigned NBUF  = 4,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned LW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned GW    = 3,
  localparam int unsigned IW = (NBUF > 1) ? $clog2(NBUF) : 1,
  localparam int unsigned SW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned TW = IW + GW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          miss_req,
  input  logic [LW-1:0] miss_line,
  output logic          ret_valid,
  output logic          ret_hit,
  output logic [DW-1:0] ret_data,
  output logic          mem_req_valid,
  output logic [LW-1:0] mem_req_line,
  output logic [TW-1:0] mem_req_tag,
  input  logic          mem_busy,
  input  logic          mem_rsp_valid,
  input  logic [TW-1:0] mem_rsp_tag,
  input  logic [DW-1:0] mem_rsp_data
);

  function automatic logic [TW-1:0] pack_tag(logic [IW-1:0] b, logic [GW-1:0] g,
                                             logic [SW-1:0] s);
    return {b, g, s};
  endfunction

  logic [NBUF-1:0] want, grant, pop, flush, rsp_wr, match;
  logic [NBUF-1:0] hv, ha;
  logic [LW-1:0]   req_line_a  [NBUF];
  logic [SW-1:0]   req_slot_a  [NBUF];
  logic [GW-1:0]   gen_a       [NBUF];
  logic [LW-1:0]   head_line_a [NBUF];
  logic [DW-1:0]   head_data_a [NBUF];

  logic [IW-1:0] gidx, sel, victim, touch_idx;
  logic          gany, any_match, accept, pop_any, alloc, stall_w;
  logic [IW-1:0] rsp_b;
  logic [GW-1:0] rsp_g;
  logic [SW-1:0] rsp_s;

  assign rsp_b = mem_rsp_tag[TW-1 -: IW];
  assign rsp_g = mem_rsp_tag[SW +: GW];
  assign rsp_s = mem_rsp_tag[SW-1:0];

  // Lowest-index head match wins.
  always_comb begin
    sel       = '0;
    any_match = 1'b0;
    for (int i = int'(NBUF) - 1; i >= 0; i--) begin
      if (match[i]) begin
        sel       = IW'(i);
        any_match = 1'b1;
      end
    end
  end

  assign accept    = miss_req && !ret_valid;
  assign pop_any   = accept && any_match && ha[sel];
  assign stall_w   = accept && any_match && !ha[sel];
  assign alloc     = accept && !any_match;
  assign touch_idx = pop_any ? sel : victim;

  genvar gi;
  generate
    for (gi = 0; gi < int'(NBUF); gi++) begin : g_buf
      assign match[gi]  = hv[gi] && (head_line_a[gi] == miss_line);
      assign pop[gi]    = pop_any && (sel == IW'(gi));
      assign flush[gi]  = alloc && (victim == IW'(gi));
      assign rsp_wr[gi] = mem_rsp_valid && (rsp_b == IW'(gi)) && (rsp_g == gen_a[gi]);

      sbp_buf #(.LW(LW), .DW(DW), .DEPTH(DEPTH), .GW(GW)) u_buf (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush        (flush[gi]),
        .flush_line   (miss_line),
        .pop          (pop[gi]),
        .grant        (grant[gi]),
        .rsp_wr       (rsp_wr[gi]),
        .rsp_slot     (rsp_s),
        .rsp_data     (mem_rsp_data),
        .want         (want[gi]),
        .req_line     (req_line_a[gi]),
        .req_slot     (req_slot_a[gi]),
        .gen          (gen_a[gi]),
        .head_valid   (hv[gi]),
        .head_arrived (ha[gi]),
        .head_line    (head_line_a[gi]),
        .head_data    (head_data_a[gi])
      );
    end
  endgenerate

  sbp_rr_arb #(.N(NBUF)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (want),
    .en      (!mem_busy),
    .gnt     (grant),
    .gnt_idx (gidx),
    .gnt_any (gany)
  );

  sbp_lru #(.N(NBUF)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch      (pop_any || alloc),
    .touch_idx  (touch_idx),
    .victim_idx (victim)
  );

  assign mem_req_valid = gany;
  assign mem_req_line  = req_line_a[gidx];
  assign mem_req_tag   = pack_tag(gidx, gen_a[gidx], req_slot_a[gidx]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ret_valid <= 1'b0;
      ret_hit   <= 1'b0;
      ret_data  <= '0;
    end else begin
      ret_valid <= pop_any || alloc;
      ret_hit   <= pop_any;
      if (pop_any) ret_data <= head_data_a[sel];
    end
  end

  p_idle_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mem_busy);
  p_ret_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ret_valid |=> !ret_valid);
  p_alloc_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (ret_valid && !ret_hit));
  p_stall_silent_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall_w |=> !ret_valid);

endmodule

// File: tb/sim_sbp_stream_prefetch.sv
module sim_sbp_stream_prefetch;
  localparam int NB = 4;
  localparam int DP = 4;
  localparam int LW = 16;
  localparam int DW = 32;
  localparam int TW = 7;

  logic          clk, rst_n;
  logic          miss_req;
  logic [LW-1:0] miss_line;
  logic          ret_valid, ret_hit;
  logic [DW-1:0] ret_data;
  logic          mem_req_valid;
  logic [LW-1:0] mem_req_line;
  logic [TW-1:0] mem_req_tag;
  logic          mem_busy;
  logic          mem_rsp_valid;
  logic [TW-1:0] mem_rsp_tag;
  logic [DW-1:0] mem_rsp_data;

  sbp_stream_prefetch u0 (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .miss_line(miss_line),
    .ret_valid(ret_valid), .ret_hit(ret_hit), .ret_data(ret_data),
    .mem_req_valid(mem_req_valid), .mem_req_line(mem_req_line),
    .mem_req_tag(mem_req_tag), .mem_busy(mem_busy),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
    .mem_rsp_data(mem_rsp_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] dat_of(logic [LW-1:0] l);
    return {l, l ^ 16'hA5C3};
  endfunction

  // ---------------- memory model ----------------
  int bus_mode = 2;   // 0 random busy, 1 always busy, 2 idle
  int lat_min = 3, lat_max = 3;
  logic [TW-1:0] pq_tag  [256];
  logic [LW-1:0] pq_line [256];
  int            pq_due  [256];
  int wr_p = 0, rd_p = 0, last_due = 0;
  logic [LW-1:0] lg_line [512];
  int            lg_buf  [512];
  int lg_n = 0;

  always @(posedge clk) begin
    if (rst_n && mem_req_valid) begin
      int d;
      d = cyc + lat_min + int'($urandom % (lat_max - lat_min + 1));
      if (d < last_due) d = last_due;
      last_due = d;
      pq_tag[wr_p % 256]  = mem_req_tag;
      pq_line[wr_p % 256] = mem_req_line;
      pq_due[wr_p % 256]  = d;
      wr_p = wr_p + 1;
      if (lg_n < 512) begin
        lg_line[lg_n] = mem_req_line;
        lg_buf[lg_n]  = int'(mem_req_tag[6:5]);
        lg_n = lg_n + 1;
      end
    end
  end

  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (rd_p != wr_p && pq_due[rd_p % 256] <= cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_tag   = pq_tag[rd_p % 256];
      mem_rsp_data  = dat_of(pq_line[rd_p % 256]);
      rd_p = rd_p + 1;
    end
    if (bus_mode == 1)      mem_busy = 1'b1;
    else if (bus_mode == 2) mem_busy = 1'b0;
    else                    mem_busy = ($urandom % 4) == 0;
  end

  // ---------------- reference model of streams (index 0 = MRU) ----------------
  logic [LW-1:0] mh [NB];
  bit            mv [NB];

  task automatic model_miss(input logic [LW-1:0] l, output bit hit);
    int p;
    logic [LW-1:0] h;
    p = -1;
    for (int i = NB - 1; i >= 0; i--) if (mv[i] && mh[i] == l) p = i;
    hit = (p >= 0);
    if (hit) h = mh[p] + 1'b1;
    else begin h = l + 1'b1; p = NB - 1; end
    for (int i = p; i > 0; i--) begin mh[i] = mh[i-1]; mv[i] = mv[i-1]; end
    mh[0] = h;
    mv[0] = 1'b1;
  endtask

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic do_miss(input logic [LW-1:0] l, output bit hit,
                         output logic [DW-1:0] d, output int lat);
    bit got;
    got = 0;
    lat = 0;
    hit = 0;
    d   = '0;
    @(negedge clk);
    miss_req  = 1'b1;
    miss_line = l;
    while (!got && lat < 200) begin
      @(posedge clk);
      #1;
      lat++;
      if (ret_valid) begin
        got = 1;
        hit = ret_hit;
        d   = ret_data;
      end
    end
    @(negedge clk);
    miss_req = 1'b0;
    if (!got) chk(0, "R2 no answer to miss", 0, 1);
  endtask

  task automatic run_miss(input logic [LW-1:0] l, input string rq, output int lat);
    bit exp_hit, hit;
    logic [DW-1:0] d;
    model_miss(l, exp_hit);
    do_miss(l, hit, d, lat);
    chk(hit == exp_hit, {rq, " hit flag"}, 32'(hit), 32'(exp_hit));
    if (exp_hit && hit) chk(d == dat_of(l), {rq, " line data"}, d, dat_of(l));
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int lat, base, nreq;
    bit ok;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NB; i++) begin mh[i] = '0; mv[i] = 0; end
    rst_n = 1'b0;
    miss_req = 1'b0;
    miss_line = '0;
    mem_busy = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_tag = '0;
    mem_rsp_data = '0;
    repeat (5) @(negedge clk);
    chk(ret_valid == 1'b0, "R1 ret_valid in reset", 32'(ret_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", 32'(mem_req_valid), 0);
    rst_n = 1'b1;
    settle(10);
    chk(ret_valid == 1'b0, "R1 ret_valid after reset", 32'(ret_valid), 0);
    chk(lg_n == 0, "R1 requests before any stream", 32'(lg_n), 0);

    // Allocation with the bus held busy, then release.
    bus_mode = 1;
    base = lg_n;
    run_miss(16'd100, "R3", lat);
    run_miss(16'd200, "R3", lat);
    run_miss(16'd300, "R3", lat);
    run_miss(16'd400, "R3", lat);
    settle(5);
    chk(lg_n == base, "R5 no request while busy", 32'(lg_n - base), 0);
    bus_mode = 2;
    lat_min = 3; lat_max = 3;
    settle(40);
    nreq = lg_n - base;
    chk(nreq == NB * DP, "R5 fills stop when full", 32'(nreq), 32'(NB * DP));
    ok = 1;
    for (int k = 1; k < NB * DP; k++)
      if (lg_buf[base + k] != (lg_buf[base + k - 1] + 1) % NB) ok = 0;
    chk(ok, "R9 round-robin queue order", 32'(lg_buf[base + 1]), 32'((lg_buf[base] + 1) % NB));
    ok = 1;
    for (int k = 0; k < NB * DP - NB; k++)
      if (lg_line[base + k + NB] != lg_line[base + k] + 1'b1) ok = 0;
    chk(ok, "R6 consecutive stream lines", 32'(lg_line[base + NB]), 32'(lg_line[base] + 1'b1));
    ok = 1;
    for (int k = 0; k < NB; k++) if (lg_line[base + k] % 100 != 1) ok = 0;
    chk(ok, "R3 first request is miss plus one", 32'(lg_line[base]), 32'(lg_line[base] / 100 * 100 + 1));

    // Hits and head advance.
    run_miss(16'd101, "R2", lat);
    run_miss(16'd102, "R10", lat);
    run_miss(16'd103, "R10", lat);

    // LRU replacement: stream of 200 is the oldest now.
    run_miss(16'd500, "R4", lat);
    settle(40);
    run_miss(16'd201, "R4 evicted stream", lat);
    settle(40);
    run_miss(16'd401, "R4 surviving stream", lat);

    // Head present but data still in flight.
    lat_min = 6; lat_max = 6;
    settle(40);
    run_miss(16'd900, "R3", lat);
    settle(2);
    run_miss(16'd901, "R7", lat);
    chk(lat >= 3, "R7 response waits for data", 32'(lat), 3);

    // Flush a queue while its fetches are outstanding.
    lat_min = 20; lat_max = 20;
    settle(40);
    run_miss(16'd1000, "R8", lat);
    run_miss(16'd1100, "R8", lat);
    run_miss(16'd1200, "R8", lat);
    run_miss(16'd1300, "R8", lat);
    run_miss(16'd1400, "R8", lat);
    settle(80);
    run_miss(16'd1401, "R8 stale data dropped", lat);
    run_miss(16'd1402, "R8 stale data dropped", lat);
    run_miss(16'd1301, "R8", lat);
    run_miss(16'd1101, "R8", lat);

    // Constrained random mix of head hits and new streams.
    lat_min = 1; lat_max = 8;
    bus_mode = 0;
    for (int it = 0; it < 150; it++) begin
      logic [LW-1:0] l;
      int p;
      settle(30);
      p = int'($urandom % NB);
      if (($urandom % 10) < 6 && mv[p]) l = mh[p];
      else l = LW'(5000 + it * 50);
      run_miss(l, "R2/R4 random", lat);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule